// File: doc/BRIEF.md
# Count-Driven Time-Slot Multiplexer

This block puts one of four single-bit data lines onto one output line. The choice does not come from an address input. A free-running binary counter inside the block makes it. The counter steps through sixteen states and then wraps. Each data line owns one state in that cycle: line 0 in state 3, line 1 in state 7, line 2 in state 11 and line 3 in state 15. During the whole clock period of its state, the selected line is passed straight through. In all other states the output is held at zero.

The counter is cleared once by a synchronous active-high reset and then runs without stopping. Each slot match compares every counter bit, so a state never aliases with another state that shares its low bits. The output is formed by AND-OR gating from the registered count and the live data lines. It has no register of its own, so a change on a data line while its slot is open shows up at the output in the same cycle. The counter value and a one-hot slot indicator are brought out, so that the logic around the block can line up with the time slots.

Top module: `slot_seq_mux`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the counter loads 0. During reset and in the cycle after it, `count_out` is 0, `slot_onehot` is 0 and `mux_out` is 0, whatever the data lines do.
- R2: Outside reset, `count_out` goes up by one on each rising edge, and goes from 15 back to 0.
- R3: `slot_onehot` bit k is 1 exactly when `count_out` equals 4k+3 (3, 7, 11, 15 for k = 0..3). Otherwise it is 0. At most one bit is ever set.
- R4: `mux_out` equals `data_in[0]` while the count is 3, `data_in[1]` at count 7, `data_in[2]` at count 11 and `data_in[3]` at count 15.
- R5: In every count other than 3, 7, 11 and 15, `mux_out` is 0 for any value of `data_in`.
- R6: The path from data to output is combinational. A change on the selected data line within its slot reaches `mux_out` in the same clock period.
- R7: A slot decode uses all four counter bits. A data line whose slot is not the current count has no effect on `mux_out`, even when the low two counter bits are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset that clears the counter |
| data_in | input | 4 | Data lines; bit k owns slot k |
| mux_out | output | 1 | Selected data line, or 0 outside the slots |
| count_out | output | 4 | Current counter value |
| slot_onehot | output | 4 | One-hot slot indicator; bit k is high in slot k |

## Verification
The assertions assume that `rst` is held high for at least two clock edges before the first release. Without that, the counter has no defined value to step from. The bench keeps to this at start-up, and a mid-run reset also spans two edges. The routing properties sample `data_in` at the clock edge. For that reason the bench changes data lines only away from the rising edge: on the falling edge, or a few time units after it in the same-cycle follow test. The output therefore always settles before the next sample.

// File: rtl/slotmux_pkg.sv
package slotmux_pkg;

  // Count value at which slot k opens: the last state of its stride.
  function automatic int slot_pos(input int k, input int stride);
    return stride * k + stride - 1;
  endfunction

endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int CNT_W  = 4,
  parameter int N_SLOT = 4
) (
  input  logic [CNT_W-1:0]  count,
  output logic [N_SLOT-1:0] hit
);

  localparam int STRIDE = (1 << CNT_W) / N_SLOT;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    localparam logic [CNT_W-1:0] POS = CNT_W'(slotmux_pkg::slot_pos(k, STRIDE));
    // full-width compare: every counter bit takes part
    assign hit[k] = (count == POS);
  end

endmodule

// File: rtl/slot_gate.sv
module slot_gate #(
  parameter int N_SLOT = 4
) (
  input  logic [N_SLOT-1:0] hit,
  input  logic [N_SLOT-1:0] data,
  output logic              y
);

  logic [N_SLOT-1:0] term;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_and
    assign term[k] = hit[k] & data[k];
  end

  assign y = |term;

endmodule

// File: rtl/slot_seq_mux.sv
module slot_seq_mux #(
  parameter int CNT_W  = 4,
  parameter int N_SLOT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SLOT-1:0] data_in,
  output logic              mux_out,
  output logic [CNT_W-1:0]  count_out,
  output logic [N_SLOT-1:0] slot_onehot
);

  logic [CNT_W-1:0]  cnt;
  logic [N_SLOT-1:0] hit;

  slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .count (cnt)
  );

  slot_decoder #(.CNT_W(CNT_W), .N_SLOT(N_SLOT)) u_dec (
    .count (cnt),
    .hit   (hit)
  );

  slot_gate #(.N_SLOT(N_SLOT)) u_gate (
    .hit  (hit),
    .data (data_in),
    .y    (mux_out)
  );

  assign count_out   = cnt;
  assign slot_onehot = hit;

endmodule

// File: rtl/slot_seq_mux_chk.sv
module slot_seq_mux_chk #(
  parameter int CNT_W  = 4,
  parameter int N_SLOT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SLOT-1:0] data_in,
  input logic              mux_out,
  input logic [CNT_W-1:0]  count_out,
  input logic [N_SLOT-1:0] slot_onehot
);

  localparam int STRIDE = (1 << CNT_W) / N_SLOT;

  // R1: the first cycle after reset starts from zero
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_out == '0 && slot_onehot == '0));

  // R2: steady stepping by one, with wrap
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count_out == CNT_W'($past(count_out) + CNT_W'(1)));

  // R3: no two slots open at once
  assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_onehot));

  // R3: a slot opens only on the last state of its stride
  assert_slot_pos_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_onehot != '0) |-> (int'(count_out) % STRIDE == STRIDE - 1));

  // R4: output carries the line of the open slot
  assert_route_R4: assert property (@(posedge clk) disable iff (rst)
    (slot_onehot != '0) |-> (mux_out == |(slot_onehot & data_in)));

  // R5: idle states drive zero
  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_onehot == '0) |-> !mux_out);

endmodule

bind slot_seq_mux slot_seq_mux_chk #(.CNT_W(CNT_W), .N_SLOT(N_SLOT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .data_in     (data_in),
  .mux_out     (mux_out),
  .count_out   (count_out),
  .slot_onehot (slot_onehot)
);

// File: tb/slot_seq_mux_tb_top.sv
module slot_seq_mux_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] data_in = 4'h0;
  logic       mux_out;
  logic [3:0] count_out;
  logic [3:0] slot_onehot;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] exp_cnt = 4'h0;

  always #5 clk = ~clk;

  slot_seq_mux dut_i (
    .clk         (clk),
    .rst         (rst),
    .data_in     (data_in),
    .mux_out     (mux_out),
    .count_out   (count_out),
    .slot_onehot (slot_onehot)
  );

  // {data pattern, expected mux_out per count (bit n = count n)}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 16'h0000},
    {4'hF, 16'h8888},
    {4'h1, 16'h0008},
    {4'h2, 16'h0080},
    {4'h4, 16'h0800},
    {4'h8, 16'h8000},
    {4'hA, 16'h8080},
    {4'h5, 16'h0808}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (count %0d)", req, act, exp, exp_cnt);
    end
  endtask

  function automatic logic [3:0] exp_slot(input logic [3:0] c);
    logic [3:0] r;
    r = 4'h0;
    for (int k = 0; k < 4; k++) if (c == 4'(4 * k + 3)) r[k] = 1'b1;
    return r;
  endfunction

  // advance one clock; returns at the following falling edge
  task automatic tick();
    @(posedge clk);
    if (rst) exp_cnt = 4'h0;
    else     exp_cnt = exp_cnt + 4'h1;
    @(negedge clk);
  endtask

  task automatic run_to(input logic [3:0] target);
    while (exp_cnt != target) tick();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset held for several edges
    rst = 1'b1;
    data_in = 4'hF;
    repeat (4) tick();
    #1;
    chk("R1 count in reset", int'(count_out), 0);
    chk("R1 slots in reset", int'(slot_onehot), 0);
    chk("R1 output in reset", int'(mux_out), 0);
    rst = 1'b0;
    exp_cnt = 4'h0;
    #1;
    chk("R1 count after release", int'(count_out), 0);

    // table walk: each pattern over a full counter period
    for (int v = 0; v < NV; v++) begin
      data_in = VEC[v][19:16];
      for (int s = 0; s < 16; s++) begin
        #1;
        chk("R2 count", int'(count_out), int'(exp_cnt));
        chk("R3 slot indicator", int'(slot_onehot), int'(exp_slot(exp_cnt)));
        chk("R4/R5 output", int'(mux_out), int'(VEC[v][exp_cnt]));
        tick();
      end
    end

    // R2: wrap from 15 to 0
    run_to(4'hF);
    #1;
    chk("R2 at 15", int'(count_out), 15);
    tick();
    #1;
    chk("R2 wrap to 0", int'(count_out), 0);

    // R6: same-cycle follow within slot 0
    run_to(4'h3);
    data_in = 4'h0;
    #1;
    chk("R6 low in slot", int'(mux_out), 0);
    data_in = 4'h1;
    #1;
    chk("R6 rise in slot", int'(mux_out), 1);
    data_in = 4'h0;
    #1;
    chk("R6 fall in slot", int'(mux_out), 0);

    // R7: other lines ignored in slot 1 (count 7, low bits 11)
    run_to(4'h7);
    data_in = 4'hD;
    #1;
    chk("R7 foreign lines in slot 1", int'(mux_out), 0);
    data_in = 4'h2;
    #1;
    chk("R7 own line in slot 1", int'(mux_out), 1);

    // R5: toggling in an idle state
    tick();
    data_in = 4'hF;
    #1;
    chk("R5 idle all high", int'(mux_out), 0);
    data_in = 4'h0;
    #1;
    chk("R5 idle all low", int'(mux_out), 0);

    // R1: reset mid-run, held two edges with data high
    run_to(4'hA);
    data_in = 4'hF;
    rst = 1'b1;
    tick();
    #1;
    chk("R1 mid-run count", int'(count_out), 0);
    chk("R1 mid-run output", int'(mux_out), 0);
    tick();
    rst = 1'b0;
    #1;
    chk("R1 still zero", int'(count_out), 0);
    tick();
    #1;
    chk("R2 restart", int'(count_out), 1);
    run_to(4'hB);
    #1;
    chk("R4 slot 2 after restart", int'(mux_out), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule